// File: doc/BRIEF.md
# In-Order Reconfiguration Start Scheduler

This block decides when a hardware task may begin loading onto a partially reconfigurable fabric. The fabric has a single configuration port. Its area is split into one slot per resource class. Task descriptors arrive one at a time, each with an arrival time, its logic, block-RAM and multiplier needs, an execution time and a deadline. The block picks the smallest class that can hold the task. It then works out the earliest start time and returns a decision: accepted with that start time, rejected as late, or rejected because no class fits.

Configuration-port grants follow the arrival order strictly. A task never starts before the previous accepted task has finished loading. Each class keeps the time at which its slot becomes free again. The reconfiguration time of a task is a property of its class, because it scales with the slot area. Time is modelled only as unsigned integer counters. Nothing is loaded or executed here.

Top module: `ordered_recfg_sched`

## Requirements
- R1: A task is placed in the lowest-numbered class whose logic, RAM and multiplier capacities all cover its needs. Default capacities for classes 0..3 are: logic 16/32/64/128, RAM 1/2/4/8, multipliers 0/2/4/8.
- R2: A task that fits no class gets status 2 (no fit), with class 0 and start 0. It changes no stored time.
- R3: The start time is the largest of the port-free time, the free time of the chosen class slot, and the arrival time. A task arriving at an idle port and an idle slot starts at its arrival time.
- R4: After an accept, the port-free time becomes start plus the class reconfiguration time. Defaults for classes 0..3 are 4/8/16/32.
- R5: After an accept, the chosen slot's free time becomes start plus reconfiguration time plus execution time.
- R6: A task is accepted (status 0) only when start + reconfiguration + execution is no greater than its deadline. Otherwise it gets status 1 (late).
- R7: A late task leaves the port-free and slot-free times unchanged.
- R8: Every handshaken task gives exactly one decision, in arrival order, two clock cycles after its handshake. A new task can be taken every cycle.
- R9: Reset clears all stored times and the output valid. The input ready is high from the first cycle after reset.
- R10: The finish-time sum is evaluated without wrap-around. A sum past the 32-bit range is treated as late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Task descriptor present |
| in_ready | output | 1 | Block can take a descriptor |
| in_arrival | input | 32 | Arrival time of the task |
| in_clb | input | 8 | Logic blocks needed |
| in_bram | input | 8 | RAM blocks needed |
| in_dsp | input | 8 | Multiplier blocks needed |
| in_exec | input | 32 | Execution time |
| in_deadline | input | 32 | Latest allowed finish time |
| out_valid | output | 1 | Decision present this cycle |
| out_status | output | 2 | 0 accepted, 1 late, 2 no fit |
| out_class | output | 2 | Chosen class |
| out_start | output | 32 | Scheduled start time |

## Verification
A corrupt port-free or slot-free time does not appear on the decision that caused it. It appears on the next task that uses the port or that class, as a start time that is too early or too late, or as a wrong accept or late status. The tests therefore always follow a critical task with a dependent one, two cycles later. A wrong class choice shows at once in the class field of the same decision, and it shifts the start times of every later task as well.

// File: rtl/ors_pkg.sv
package ors_pkg;
    typedef enum logic [1:0] {
        ST_ACCEPT = 2'd0,
        ST_LATE   = 2'd1,
        ST_NOFIT  = 2'd2
    } status_e;
endpackage

// File: rtl/ors_classify.sv
module ors_classify #(
    parameter int NUM_CLASS = 4,
    parameter int RW        = 8,
    parameter int TW        = 32,
    parameter int CW        = 2,
    parameter logic [NUM_CLASS*RW-1:0] CLASS_CLB  = {8'd128, 8'd64, 8'd32, 8'd16},
    parameter logic [NUM_CLASS*RW-1:0] CLASS_BRAM = {8'd8, 8'd4, 8'd2, 8'd1},
    parameter logic [NUM_CLASS*RW-1:0] CLASS_DSP  = {8'd8, 8'd4, 8'd2, 8'd0}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [RW-1:0] clb,
    input  logic [RW-1:0] bram,
    input  logic [RW-1:0] dsp,
    input  logic [TW-1:0] arrival,
    input  logic [TW-1:0] exec_t,
    input  logic [TW-1:0] deadline,
    output logic          ready,
    output logic          s1_valid,
    output logic          s1_fit,
    output logic [CW-1:0] s1_class,
    output logic [TW-1:0] s1_arrival,
    output logic [TW-1:0] s1_exec,
    output logic [TW-1:0] s1_deadline
);
    typedef struct packed {
        logic          ready;
        logic          valid;
        logic          fit;
        logic [CW-1:0] cls;
        logic [TW-1:0] arrival;
        logic [TW-1:0] exec_t;
        logic [TW-1:0] deadline;
    } stage_t;

    stage_t st_d, st_q;
    logic [NUM_CLASS-1:0] fit_vec;

    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_fit
        assign fit_vec[g] = (clb  <= CLASS_CLB[g*RW +: RW]) &&
                            (bram <= CLASS_BRAM[g*RW +: RW]) &&
                            (dsp  <= CLASS_DSP[g*RW +: RW]);
    end

    always_comb begin
        st_d          = st_q;
        st_d.ready    = 1'b1;
        st_d.valid    = take;
        st_d.fit      = 1'b0;
        st_d.cls      = '0;
        st_d.arrival  = arrival;
        st_d.exec_t   = exec_t;
        st_d.deadline = deadline;
        for (int i = NUM_CLASS - 1; i >= 0; i--) begin
            if (fit_vec[i]) begin
                st_d.fit = 1'b1;
                st_d.cls = CW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready       = st_q.ready;
    assign s1_valid    = st_q.valid;
    assign s1_fit      = st_q.fit;
    assign s1_class    = st_q.cls;
    assign s1_arrival  = st_q.arrival;
    assign s1_exec     = st_q.exec_t;
    assign s1_deadline = st_q.deadline;

    AST_CLASS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_fit) |-> (32'(s1_class) < NUM_CLASS)); // R1
    AST_STAGE_FOLLOWS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> $past(take)); // R8
endmodule

// File: rtl/ors_admit.sv
module ors_admit
    import ors_pkg::*;
#(
    parameter int NUM_CLASS = 4,
    parameter int TW        = 32,
    parameter int CW        = 2,
    parameter logic [NUM_CLASS*TW-1:0] CLASS_RECFG = {32'd32, 32'd16, 32'd8, 32'd4}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s1_valid,
    input  logic          s1_fit,
    input  logic [CW-1:0] s1_class,
    input  logic [TW-1:0] s1_arrival,
    input  logic [TW-1:0] s1_exec,
    input  logic [TW-1:0] s1_deadline,
    output logic          out_valid,
    output logic [1:0]    out_status,
    output logic [CW-1:0] out_class,
    output logic [TW-1:0] out_start
);
    localparam int EW = TW + 2;

    typedef struct packed {
        logic [TW-1:0]                port_free;
        logic [NUM_CLASS-1:0][TW-1:0] slot_free;
        logic                         valid;
        status_e                      status;
        logic [CW-1:0]                cls;
        logic [TW-1:0]                start;
    } sched_t;

    sched_t st_d, st_q;

    logic [TW-1:0] recfg_t;
    logic [TW-1:0] slot_t;
    logic [TW-1:0] start_t;
    logic [EW-1:0] finish_t;
    logic [EW-1:0] loaded_t;
    logic          in_time;

    always_comb begin
        recfg_t = '0;
        slot_t  = '0;
        for (int i = 0; i < NUM_CLASS; i++) begin
            if (s1_class == CW'(i)) begin
                recfg_t = CLASS_RECFG[i*TW +: TW];
                slot_t  = st_q.slot_free[i];
            end
        end
        start_t = st_q.port_free;
        if (slot_t > start_t)     start_t = slot_t;
        if (s1_arrival > start_t) start_t = s1_arrival;
        loaded_t = EW'(start_t) + EW'(recfg_t);
        finish_t = loaded_t + EW'(s1_exec);
        in_time  = (finish_t <= EW'(s1_deadline));
    end

    always_comb begin
        st_d        = st_q;
        st_d.valid  = s1_valid;
        st_d.status = ST_NOFIT;
        st_d.cls    = '0;
        st_d.start  = '0;
        if (s1_valid && s1_fit) begin
            st_d.cls   = s1_class;
            st_d.start = start_t;
            if (in_time) begin
                st_d.status    = ST_ACCEPT;
                st_d.port_free = loaded_t[TW-1:0];
                for (int i = 0; i < NUM_CLASS; i++) begin
                    if (s1_class == CW'(i)) begin
                        st_d.slot_free[i] = finish_t[TW-1:0];
                    end
                end
            end else begin
                st_d.status = ST_LATE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_status = st_q.status;
    assign out_class  = st_q.cls;
    assign out_start  = st_q.start;

    AST_PORT_NEVER_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.port_free >= $past(st_q.port_free)); // R4
    AST_PORT_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && st_q.status == ST_ACCEPT) |-> (st_q.port_free >= st_q.start)); // R4
    AST_SLOT_AFTER_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && st_q.status == ST_ACCEPT) |-> (st_q.slot_free[st_q.cls] >= st_q.port_free)); // R5
    AST_LATE_KEEPS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && st_q.status != ST_ACCEPT) |-> $stable(st_q.port_free)); // R7
    AST_DECISION_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(s1_valid)); // R8
endmodule

// File: rtl/ordered_recfg_sched.sv
module ordered_recfg_sched #(
    parameter int NUM_CLASS = 4,
    parameter int RW        = 8,
    parameter int TW        = 32,
    parameter logic [NUM_CLASS*RW-1:0] CLASS_CLB   = {8'd128, 8'd64, 8'd32, 8'd16},
    parameter logic [NUM_CLASS*RW-1:0] CLASS_BRAM  = {8'd8, 8'd4, 8'd2, 8'd1},
    parameter logic [NUM_CLASS*RW-1:0] CLASS_DSP   = {8'd8, 8'd4, 8'd2, 8'd0},
    parameter logic [NUM_CLASS*TW-1:0] CLASS_RECFG = {32'd32, 32'd16, 32'd8, 32'd4},
    localparam int CW = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [TW-1:0] in_arrival,
    input  logic [RW-1:0] in_clb,
    input  logic [RW-1:0] in_bram,
    input  logic [RW-1:0] in_dsp,
    input  logic [TW-1:0] in_exec,
    input  logic [TW-1:0] in_deadline,
    output logic          out_valid,
    output logic [1:0]    out_status,
    output logic [CW-1:0] out_class,
    output logic [TW-1:0] out_start
);
    logic          take;
    logic          s1_valid;
    logic          s1_fit;
    logic [CW-1:0] s1_class;
    logic [TW-1:0] s1_arrival;
    logic [TW-1:0] s1_exec;
    logic [TW-1:0] s1_deadline;

    assign take = in_valid && in_ready;

    ors_classify #(
        .NUM_CLASS (NUM_CLASS),
        .RW        (RW),
        .TW        (TW),
        .CW        (CW),
        .CLASS_CLB (CLASS_CLB),
        .CLASS_BRAM(CLASS_BRAM),
        .CLASS_DSP (CLASS_DSP)
    ) u_classify (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .clb        (in_clb),
        .bram       (in_bram),
        .dsp        (in_dsp),
        .arrival    (in_arrival),
        .exec_t     (in_exec),
        .deadline   (in_deadline),
        .ready      (in_ready),
        .s1_valid   (s1_valid),
        .s1_fit     (s1_fit),
        .s1_class   (s1_class),
        .s1_arrival (s1_arrival),
        .s1_exec    (s1_exec),
        .s1_deadline(s1_deadline)
    );

    ors_admit #(
        .NUM_CLASS  (NUM_CLASS),
        .TW         (TW),
        .CW         (CW),
        .CLASS_RECFG(CLASS_RECFG)
    ) u_admit (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_valid   (s1_valid),
        .s1_fit     (s1_fit),
        .s1_class   (s1_class),
        .s1_arrival (s1_arrival),
        .s1_exec    (s1_exec),
        .s1_deadline(s1_deadline),
        .out_valid  (out_valid),
        .out_status (out_status),
        .out_class  (out_class),
        .out_start  (out_start)
    );

    AST_NOFIT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_status == 2'd2) |-> (out_class == '0 && out_start == '0)); // R2
endmodule

// File: tb/ordered_recfg_sched_test.sv
`timescale 1ns/100ps
module ordered_recfg_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_arrival = '0;
    logic [7:0]  in_clb = '0;
    logic [7:0]  in_bram = '0;
    logic [7:0]  in_dsp = '0;
    logic [31:0] in_exec = '0;
    logic [31:0] in_deadline = '0;
    logic        out_valid;
    logic [1:0]  out_status;
    logic [1:0]  out_class;
    logic [31:0] out_start;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ordered_recfg_sched uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_arrival(in_arrival), .in_clb(in_clb), .in_bram(in_bram), .in_dsp(in_dsp),
        .in_exec(in_exec), .in_deadline(in_deadline), .out_valid(out_valid),
        .out_status(out_status), .out_class(out_class), .out_start(out_start)
    );

    task automatic check_val(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put(logic [31:0] arr, logic [7:0] c, logic [7:0] b, logic [7:0] d,
                       logic [31:0] ex, logic [31:0] dl);
        in_valid = 1'b1;
        in_arrival = arr; in_clb = c; in_bram = b; in_dsp = d;
        in_exec = ex; in_deadline = dl;
    endtask

    task automatic expect_out(string req, logic [1:0] st, logic [1:0] cl, logic [31:0] sta);
        check_val(req, "valid", 32'(out_valid), 1);
        check_val(req, "status", 32'(out_status), 32'(st));
        check_val(req, "class", 32'(out_class), 32'(cl));
        check_val(req, "start", out_start, sta);
    endtask

    task automatic send_one(string req, logic [31:0] arr, logic [7:0] c, logic [7:0] b,
                            logic [7:0] d, logic [31:0] ex, logic [31:0] dl,
                            logic [1:0] st, logic [1:0] cl, logic [31:0] sta);
        @(negedge clk);
        put(arr, c, b, d, ex, dl);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        expect_out(req, st, cl, sta);
    endtask

    task automatic test_reset();
        do_reset();
        check_val("R9", "out_valid after reset", 32'(out_valid), 0);
        check_val("R9", "in_ready after reset", 32'(in_ready), 1);
    endtask

    task automatic test_classes();
        do_reset();
        send_one("R1", 0, 8'd10, 8'd1, 8'd0, 1, 1000, 2'd0, 2'd0, 0);
        send_one("R1_R4", 0, 8'd20, 8'd1, 8'd0, 1, 1000, 2'd0, 2'd1, 4);
        send_one("R1_R4", 0, 8'd10, 8'd0, 8'd3, 1, 1000, 2'd0, 2'd2, 12);
        send_one("R1_R4", 0, 8'd10, 8'd5, 8'd0, 1, 1000, 2'd0, 2'd3, 28);
        send_one("R5", 0, 8'd128, 8'd8, 8'd8, 1, 1000, 2'd0, 2'd3, 61);
    endtask

    task automatic test_nofit();
        do_reset();
        send_one("R2", 3, 8'd200, 8'd0, 8'd0, 1, 1000, 2'd2, 2'd0, 0);
        send_one("R2", 3, 8'd1, 8'd9, 8'd0, 1, 1000, 2'd2, 2'd0, 0);
        send_one("R3", 7, 8'd1, 8'd0, 8'd0, 1, 1000, 2'd0, 2'd0, 7);
    endtask

    task automatic test_arrival_dominates();
        do_reset();
        send_one("R3", 50, 8'd1, 8'd0, 8'd0, 2, 1000, 2'd0, 2'd0, 50);
        send_one("R3", 53, 8'd1, 8'd0, 8'd0, 2, 1000, 2'd0, 2'd0, 56);
        send_one("R3", 100, 8'd40, 8'd0, 8'd0, 2, 1000, 2'd0, 2'd2, 100);
    endtask

    task automatic test_deadline();
        do_reset();
        send_one("R6", 0, 8'd1, 8'd0, 8'd0, 6, 10, 2'd0, 2'd0, 0);
        send_one("R6", 0, 8'd1, 8'd0, 8'd0, 6, 19, 2'd1, 2'd0, 10);
        send_one("R7", 0, 8'd20, 8'd0, 8'd0, 1, 100, 2'd0, 2'd1, 4);
        send_one("R7", 0, 8'd1, 8'd0, 8'd0, 1, 100, 2'd0, 2'd0, 12);
    endtask

    task automatic test_overflow();
        do_reset();
        send_one("R10", 32'hFFFF_FFF0, 8'd1, 8'd0, 8'd0, 32'h100, 32'hFFFF_FFFF,
                 2'd1, 2'd0, 32'hFFFF_FFF0);
        send_one("R10", 5, 8'd1, 8'd0, 8'd0, 1, 100, 2'd0, 2'd0, 5);
    endtask

    task automatic test_back_to_back();
        do_reset();
        @(negedge clk);
        put(0, 8'd1, 8'd0, 8'd0, 1, 100);
        @(negedge clk);
        check_val("R8", "no output one cycle after", 32'(out_valid), 0);
        put(0, 8'd1, 8'd0, 8'd0, 1, 100);
        @(negedge clk);
        expect_out("R8", 2'd0, 2'd0, 0);
        put(0, 8'd20, 8'd0, 8'd0, 1, 100);
        @(negedge clk);
        in_valid = 1'b0;
        expect_out("R8", 2'd0, 2'd0, 5);
        @(negedge clk);
        expect_out("R8", 2'd0, 2'd1, 9);
        @(negedge clk);
        check_val("R8", "output ends", 32'(out_valid), 0);
    endtask

    initial begin
        test_reset();
        test_classes();
        test_nofit();
        test_arrival_dominates();
        test_deadline();
        test_overflow();
        test_back_to_back();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule